// File: doc/BRIEF.md
# Frame Alignment Offset Meter

This block measures how late a serial-bus frame-evaluation input arrives relative to the local frame boundary. It counts whole bus-clock cycles and resolves the remaining half cycle. Software arms a measurement by setting a start bit. The block waits for the next local frame pulse and counts bus-clock cycles from that point. It records the cycle count and the bus-clock phase at which the first qualifying transition of the evaluation input was seen. In the default bus mode that transition is a falling edge. In the alternate mode it is a rising edge.

The block runs from a system clock at twice the bus-clock rate. It takes the bus clock, the frame pulse and the evaluation input as data. All three pass through the same synchronizer depth, so their relative timing is preserved and the reported offset needs no correction. The result is a 16-bit status word returned on a read port at one register address. It holds a completion flag, a phase bit and an 11-bit cycle offset. The result stays frozen while the start bit remains set, and it is wiped when the start bit is cleared.

Top module: `fe_align_meter`

## Requirements
- R1: After reset the status word reads 0000h.
- R2: A read at address 02h returns {3'b000, done, phase, offset[10:0]}: done in bit 12, phase in bit 11, offset in bits 10..0. Bits 15..13 are always zero. Any other address reads 0000h.
- R3: With gci_mode=0, a falling edge of fe during the low half of bus cycle 6 after the frame pulse reads 1006h (done=1, phase=0, offset=6).
- R4: With gci_mode=1, a rising edge of fe during the high half of bus cycle 9 reads 1809h (done=1, phase=1, offset=9).
- R5: An fe transition in the non-measured direction is not captured. A later transition in the measured direction is captured with its own offset.
- R6: Only the first measured edge after arming is captured. Later edges and later frame pulses leave the status unchanged while sfe stays 1.
- R7: When sfe falls from 1 to 0, done, phase and offset all return to zero.
- R8: Edges that arrive after arming but before the frame pulse are ignored. The frame pulse's own bus cycle counts as cycle 0, so an edge in its high half reads 1800h.
- R9: If no measured edge occurs within cycles 0..2047, the counter stops, done stays 0 and the status reads 0000h. A later edge is still ignored.
- R10: An edge in the low half of cycle 2047, the last countable cycle, reads 17FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, twice the bus-clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk | input | 1 | Bus clock level, sampled once per system clock |
| frame_p | input | 1 | Local frame pulse, active high, rising with a bus-clock high half |
| fe | input | 1 | Frame-evaluation input being measured |
| sfe | input | 1 | Start bit: rising arms a measurement, falling clears the result |
| gci_mode | input | 1 | 0: measure fe falling edge; 1: measure fe rising edge |
| reg_addr | input | 8 | Read address |
| reg_rdata | output | 16 | Status word at address 02h, else zero |

## Verification
The assertions assume that bclk alternates on every system clock, so each bus cycle is exactly one high sample followed by one low sample. They also assume that the frame pulse rises together with a high half. They further assume that sfe and gci_mode change only while no measurement is in progress, and that the counter can only climb between the frame pulse and the end of the measurement. The bench drives every input at the falling system-clock edge, one value per bus-clock half. It starts each frame pulse on a high half, and it changes the mode only while sfe is low. The monotonic-count and freeze properties therefore hold at every edge the checker samples.

// File: rtl/fe_align_meter.sv
module fe_align_meter #(
  parameter int CNT_W = 11,
  parameter int AW = 8,
  parameter logic [AW-1:0] REG_ADDR = 8'h02,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bclk,
  input  logic          frame_p,
  input  logic          fe,
  input  logic          sfe,
  input  logic          gci_mode,
  input  logic [AW-1:0] reg_addr,
  output logic [15:0]   reg_rdata
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  typedef enum logic [2:0] {S_IDLE, S_ARMED, S_COUNT, S_DONE, S_STOP} st_t;

  st_t state;
  logic [SYNC-1:0] sy_b, sy_f, sy_e;
  logic pb, pf, pe, sfe_q;
  logic [CNT_W-1:0] cnt, fd, cur;
  logic cfe, ph;
  logic [15:0] status;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy_b <= '0; sy_f <= '0; sy_e <= '0;
      pb <= 1'b0; pf <= 1'b0; pe <= 1'b0;
    end else begin
      sy_b <= {sy_b[SYNC-2:0], bclk};
      sy_f <= {sy_f[SYNC-2:0], frame_p};
      sy_e <= {sy_e[SYNC-2:0], fe};
      pb <= sy_b[SYNC-1];
      pf <= sy_f[SYNC-1];
      pe <= sy_e[SYNC-1];
    end
  end

  wire b_now  = sy_b[SYNC-1];
  wire e_now  = sy_e[SYNC-1];
  wire b_rise = b_now & ~pb;
  wire f_rise = sy_f[SYNC-1] & ~pf;
  wire e_hit  = gci_mode ? (e_now & ~pe) : (~e_now & pe);
  wire wrap   = (state == S_COUNT) && b_rise && (cnt == CMAX);
  wire live   = ((state == S_COUNT) && !wrap) || ((state == S_ARMED) && f_rise);

  assign cur = f_rise ? '0 : (b_rise ? cnt + 1'b1 : cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; sfe_q <= 1'b0;
      cnt <= '0; fd <= '0; cfe <= 1'b0; ph <= 1'b0;
    end else begin
      sfe_q <= sfe;
      if (!sfe) begin
        state <= S_IDLE;
        cnt <= '0; fd <= '0; cfe <= 1'b0; ph <= 1'b0;
      end else if (!sfe_q) begin
        state <= S_ARMED;
      end else if (wrap) begin
        state <= S_STOP;
      end else if (live) begin
        cnt <= cur;
        if (e_hit) begin
          fd <= cur; ph <= b_now; cfe <= 1'b1;
          state <= S_DONE;
        end else begin
          state <= S_COUNT;
        end
      end
    end
  end

  assign status    = 16'({cfe, ph, fd});
  assign reg_rdata = (reg_addr == REG_ADDR) ? status : 16'h0000;

  a_r7_clear_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sfe) |=> (status == 16'h0000));

  a_r6_frozen_while_set: assert property (@(posedge clk) disable iff (!rst_n)
    (cfe && sfe) |=> $stable(status));

  a_r6_done_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    cfe |-> $past(sfe));

  a_r8_count_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_COUNT && $past(state) == S_COUNT) |-> (cnt >= $past(cnt)));

  a_r9_stop_not_done: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_STOP) |-> !cfe);
endmodule

// File: tb/fe_align_meter_tb.sv
`timescale 1ns/1ps
module fe_align_meter_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, bclk = 1'b0, frame_p = 1'b0, fe = 1'b1;
  logic sfe = 1'b0, gci_mode = 1'b0;
  logic [7:0] reg_addr = 8'h02;
  logic [15:0] reg_rdata;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  fe_align_meter dut_i (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .frame_p(frame_p), .fe(fe),
    .sfe(sfe), .gci_mode(gci_mode), .reg_addr(reg_addr), .reg_rdata(reg_rdata)
  );

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic half(input logic b, input logic fp, input logic v);
    @(negedge clk);
    bclk = b; frame_p = fp; fe = v;
  endtask

  task automatic idle(input int n, input logic lvl);
    for (int i = 0; i < n; i++) begin
      half(1'b1, 1'b0, lvl);
      half(1'b0, 1'b0, lvl);
    end
  endtask

  task automatic run_frame(input int ncyc, input logic lvl, input int t0, input int t1,
                           input int t2, output logic fin);
    logic v;
    v = lvl;
    for (int n = 0; n < ncyc; n++) begin
      for (int h = 0; h < 2; h++) begin
        int hi;
        hi = 2 * n + h;
        v = lvl;
        if (t0 >= 0 && hi >= t0) v = ~v;
        if (t1 >= 0 && hi >= t1) v = ~v;
        if (t2 >= 0 && hi >= t2) v = ~v;
        half(h == 0, n == 0, v);
      end
    end
    fin = v;
  endtask

  task automatic read_at(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
    reg_addr = 8'h02;
  endtask

  task automatic arm(input logic lvl);
    @(negedge clk); sfe = 1'b1;
    idle(2, lvl);
  endtask

  task automatic disarm(input logic lvl);
    @(negedge clk); sfe = 1'b0;
    idle(2, lvl);
  endtask

  task automatic t_reset;
    logic [15:0] d;
    read_at(8'h02, d);
    check("R1 reset status", d, 16'h0000);
  endtask

  task automatic t_stbus;
    logic [15:0] d; logic f;
    arm(1'b1);
    run_frame(10, 1'b1, 13, -1, -1, f);
    idle(3, f);
    read_at(8'h02, d);
    check("R3 stbus low phase cycle 6", d, 16'h1006);
    read_at(8'h03, d);
    check("R2 other address zero", d, 16'h0000);
    read_at(8'h02, d);
    check("R2 upper bits zero", {d[15:13], 13'h0}, 16'h0000);
    disarm(f);
    read_at(8'h02, d);
    check("R7 clear after sfe fall", d, 16'h0000);
  endtask

  task automatic t_gci;
    logic [15:0] d; logic f;
    gci_mode = 1'b1;
    idle(2, 1'b0);
    arm(1'b0);
    run_frame(12, 1'b0, 18, -1, -1, f);
    idle(3, f);
    read_at(8'h02, d);
    check("R4 gci high phase cycle 9", d, 16'h1809);
    disarm(f);
    gci_mode = 1'b0;
    idle(2, 1'b1);
  endtask

  task automatic t_wrong_dir;
    logic [15:0] d; logic f;
    idle(3, 1'b0);
    arm(1'b0);
    run_frame(8, 1'b0, 6, 10, -1, f);
    idle(3, f);
    read_at(8'h02, d);
    check("R5 rising ignored, falling at cycle 5 high", d, 16'h1805);
    disarm(f);
    idle(2, 1'b1);
  endtask

  task automatic t_preframe;
    logic [15:0] d; logic f;
    arm(1'b1);
    idle(1, 1'b0);
    idle(1, 1'b1);
    run_frame(6, 1'b1, 5, -1, -1, f);
    idle(3, f);
    read_at(8'h02, d);
    check("R8 pre-frame edges ignored", d, 16'h1002);
    disarm(f);
    arm(1'b1);
    run_frame(4, 1'b1, 0, -1, -1, f);
    idle(3, f);
    read_at(8'h02, d);
    check("R8 edge in frame cycle 0 high", d, 16'h1800);
    disarm(f);
    idle(2, 1'b1);
  endtask

  task automatic t_first_only;
    logic [15:0] d; logic f;
    arm(1'b1);
    run_frame(12, 1'b1, 8, 12, 16, f);
    idle(3, f);
    read_at(8'h02, d);
    check("R6 first edge only", d, 16'h1804);
    run_frame(14, f, 20, 21, -1, f);
    idle(3, f);
    read_at(8'h02, d);
    check("R6 frozen over second frame", d, 16'h1804);
    disarm(f);
    read_at(8'h02, d);
    check("R7 cleared again", d, 16'h0000);
    idle(2, 1'b1);
  endtask

  task automatic t_saturate;
    logic [15:0] d; logic f;
    arm(1'b1);
    run_frame(2050, 1'b1, -1, -1, -1, f);
    idle(3, f);
    read_at(8'h02, d);
    check("R9 no edge, done stays 0", d, 16'h0000);
    idle(2, 1'b0);
    read_at(8'h02, d);
    check("R9 late edge ignored", d, 16'h0000);
    disarm(1'b1);
    arm(1'b1);
    run_frame(2049, 1'b1, 4095, -1, -1, f);
    idle(3, f);
    read_at(8'h02, d);
    check("R10 edge at cycle 2047 low", d, 16'h17FF);
    disarm(f);
  endtask

  initial begin
    #800000;
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle(3, 1'b1);
    @(negedge clk); rst_n = 1'b1;
    idle(2, 1'b1);
    t_reset();
    t_stbus();
    t_gci();
    t_wrong_dir();
    t_preframe();
    t_first_only();
    t_saturate();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule